// File: doc/BRIEF.md
# Gray-Coded Count Transfer Between Clock Domains

This block moves a running count from one clock domain into a second, unrelated one. On the source side, an increment enable advances a binary counter. Alongside it, a register holds the Gray-coded form of that count. Because this register is driven straight from a flop, the bus that leaves the source domain changes by one bit per source clock edge at most.

On the destination side, every bit of that bus has its own two-flop synchronizer on the destination clock. The synchronized code is then turned back into binary and registered onto the output. The destination side applies no per-bit filter and does not check the received code. When the destination samples while a single bit is changing, it sees either the previous count or the next one.

A typical use is a pointer or event count that another clock domain must observe. When the source runs slower, the observer sees every value. When the source runs faster, the observer sees an ordered subset of the values.

Top module: `gray_count_xfer`

## Requirements
- R1: While `dst_rst_n` is low, `dst_count` is 0. Every register in both domains resets to zero, so after both resets are released, with no increments, the output stays 0.
- R2: The source Gray register holds `b ^ (b >> 1)` of the binary count. It changes in at most one bit on any source clock edge, including the edge where the count wraps.
- R3: When `src_inc` is high at a rising `src_clk` edge, the count advances by one modulo 2^WIDTH. When `src_inc` is low, the count holds and `dst_count` does not change.
- R4: Each bit passes through two destination flops. A registered decoder then forms binary by a running XOR from the most significant bit downward. Within six destination cycles after the source stops changing, `dst_count` equals the source count. `dst_count` holds whenever the synchronized code held at the previous destination edge.
- R5: When the source clock is slower than the destination clock, `dst_count` shows every value the source produces, in order, with none skipped.
- R6: When the source clock is faster than the destination clock, `dst_count` shows only values the source produced, in the order they were produced. Values in between may be skipped.
- R7: The step from 2^WIDTH-1 to 0 appears at the output as 0 directly after the maximum value.
- R8: The two resets are independent. A destination reset clears only `dst_count`, and after release the output returns to the unchanged source count. A source reset clears the source count, and the output follows it to 0 without any destination reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| src_inc | input | 1 | Advance the count on this source edge |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| dst_count | output | WIDTH | Count as seen in the destination domain, binary |

## Verification
The collision that matters here is a source Gray step landing in the same instant as a destination sampling edge. In that case, the first synchronizer stage captures a bit that is still changing. To provoke it, the source is run at a 3 ns period against the 8 ns destination clock. The two edges then drift across each other, and many steps land next to a sampling edge. A scoreboard holds every value the source produced and accepts each new output only if it matches a queued value at or after the last match. Any unrelated code, or any step backwards, is a failure. In the slow phase, the scoreboard also rejects any skipped value.

// File: rtl/gcx_pkg.sv
`timescale 1ns/1ps
package gcx_pkg;

    // Binary to reflected Gray code, 32-bit container.
    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary: running XOR from the top bit down.
    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] r;
        r[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            r[i] = r[i+1] ^ g[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/gcx_src_counter.sv
`timescale 1ns/1ps
module gcx_src_counter #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [WIDTH-1:0] gray_q
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] bin_q;
    logic [WIDTH-1:0] bin_nxt;
    logic [WIDTH-1:0] gray_nxt;
    logic [31:0]      gray_wide;

    always_comb begin
        bin_nxt   = bin_q + ONE;
        gray_wide = gcx_pkg::bin_to_gray(32'(bin_nxt));
        gray_nxt  = gray_wide[WIDTH-1:0];
    end

    // Binary and Gray are kept side by side so the crossing bus is a flop output.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else if (inc) begin
            bin_q  <= bin_nxt;
            gray_q <= gray_nxt;
        end
    end
endmodule

// File: rtl/gcx_sync_bit.sv
`timescale 1ns/1ps
module gcx_sync_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            q      <= 1'b0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gcx_gray_decode.sv
`timescale 1ns/1ps
module gcx_gray_decode #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] gray_in,
    output logic [WIDTH-1:0] bin_q
);
    logic [WIDTH-1:0] bin_c;

    always_comb begin
        bin_c[WIDTH-1] = gray_in[WIDTH-1];
        for (int i = WIDTH - 2; i >= 0; i--) begin
            bin_c[i] = bin_c[i+1] ^ gray_in[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q <= '0;
        end else begin
            bin_q <= bin_c;
        end
    end
endmodule

// File: rtl/gray_count_xfer.sv
`timescale 1ns/1ps
module gray_count_xfer #(
    parameter int WIDTH = 4
) (
    input  logic             src_clk,
    input  logic             src_rst_n,
    input  logic             src_inc,
    input  logic             dst_clk,
    input  logic             dst_rst_n,
    output logic [WIDTH-1:0] dst_count
);
    logic [WIDTH-1:0] src_gray;
    logic [WIDTH-1:0] sync_gray;

    gcx_src_counter #(.WIDTH(WIDTH)) u_src (
        .clk    (src_clk),
        .rst_n  (src_rst_n),
        .inc    (src_inc),
        .gray_q (src_gray)
    );

    // One independent two-flop chain per bit of the crossing bus.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        gcx_sync_bit u_sync (
            .clk   (dst_clk),
            .rst_n (dst_rst_n),
            .d     (src_gray[b]),
            .q     (sync_gray[b])
        );
    end

    gcx_gray_decode #(.WIDTH(WIDTH)) u_dec (
        .clk     (dst_clk),
        .rst_n   (dst_rst_n),
        .gray_in (sync_gray),
        .bin_q   (dst_count)
    );
endmodule

// File: rtl/gray_count_xfer_chk.sv
`timescale 1ns/1ps
module gray_count_xfer_chk #(
    parameter int WIDTH = 4
) (
    input logic             src_clk,
    input logic             src_rst_n,
    input logic             src_inc,
    input logic             dst_clk,
    input logic             dst_rst_n,
    input logic [WIDTH-1:0] src_gray,
    input logic [WIDTH-1:0] sync_gray,
    input logic [WIDTH-1:0] dst_count
);
    localparam logic [31:0] MASK = (32'd1 << WIDTH) - 32'd1;

    // R1
    dst_zero_in_reset_chk: assert property (@(posedge dst_clk)
        !dst_rst_n |-> dst_count == '0);

    // R2
    gray_one_bit_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        $countones(src_gray ^ $past(src_gray)) <= 1);

    // R3
    count_hold_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        !$past(src_inc) |-> $stable(src_gray));

    // R3
    count_step_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        $past(src_inc) |->
        ((gcx_pkg::gray_to_bin(32'(src_gray)) & MASK) ==
         ((gcx_pkg::gray_to_bin(32'($past(src_gray))) + 32'd1) & MASK)));

    // R4
    out_hold_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        $stable(sync_gray) |=> $stable(dst_count));
endmodule

bind gray_count_xfer gray_count_xfer_chk #(.WIDTH(WIDTH)) u_chk (
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .src_inc   (src_inc),
    .dst_clk   (dst_clk),
    .dst_rst_n (dst_rst_n),
    .src_gray  (src_gray),
    .sync_gray (sync_gray),
    .dst_count (dst_count)
);

// File: tb/gray_count_xfer_bench.sv
`timescale 1ns/1ps
module gray_count_xfer_bench;
    localparam int W = 4;
    localparam int M = 1 << W;

    logic         src_clk   = 1'b0;
    logic         dst_clk   = 1'b0;
    logic         src_rst_n = 1'b1;
    logic         dst_rst_n = 1'b1;
    logic         src_inc   = 1'b0;
    logic [W-1:0] dst_count;

    realtime src_half = 14.5;

    int checks   = 0;
    int fails    = 0;
    bit finished = 0;

    int           model     = 0;
    logic [W-1:0] exp_q[$];
    bit           mon_en    = 0;
    bit           slow_mode = 1;
    logic [W-1:0] last_seen = '0;
    int           skips     = 0;
    logic [W-1:0] pop_v;
    logic [W-1:0] front_v;
    int           drop;
    bit           hit;

    gray_count_xfer #(.WIDTH(W)) u_gray_count_xfer (
        .src_clk   (src_clk),
        .src_rst_n (src_rst_n),
        .src_inc   (src_inc),
        .dst_clk   (dst_clk),
        .dst_rst_n (dst_rst_n),
        .dst_count (dst_count)
    );

    always #4 dst_clk = ~dst_clk;
    always #(src_half) src_clk = ~src_clk;

    // Reference count, pushed into the scoreboard on each accepted increment.
    always @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) begin
            model = 0;
        end else if (src_inc) begin
            model = (model + 1) % M;
            exp_q.push_back(W'(model));
        end
    end

    // Monitor: each new output value must match a queued value, in order.
    always @(negedge dst_clk) begin
        if (!mon_en) begin
            last_seen = dst_count;
        end else if (dst_count !== last_seen) begin
            hit     = 0;
            drop    = 0;
            front_v = (exp_q.size() > 0) ? exp_q[0] : last_seen;
            while (exp_q.size() > 0 && !hit) begin
                pop_v = exp_q.pop_front();
                if (pop_v == dst_count) hit = 1;
                else drop++;
            end
            checks++;
            if (!hit) begin
                fails++;
                $display("FAIL R6 unproduced or reordered value actual=%0d expected=%0d",
                         dst_count, front_v);
            end else if (slow_mode && drop > 0) begin
                fails++;
                $display("FAIL R5 skipped value actual=%0d expected=%0d",
                         dst_count, front_v);
            end
            skips     = skips + drop;
            last_seen = dst_count;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_dst(input int n);
        repeat (n) @(negedge dst_clk);
    endtask

    task automatic drive_incs(input int n);
        @(negedge src_clk);
        src_inc = 1'b1;
        repeat (n) @(negedge src_clk);
        src_inc = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #1;
        src_rst_n = 1'b0;
        dst_rst_n = 1'b0;
        wait_dst(3);
        chk("R1 output in reset", int'(dst_count), 0);
        src_rst_n = 1'b1;
        dst_rst_n = 1'b1;
        wait_dst(6);
        chk("R1 output after release", int'(dst_count), 0);
        last_seen = dst_count;
        mon_en    = 1;

        // Slow source: every value in order, then the wrap.
        drive_incs(15);
        wait_dst(6);
        chk("R5 slow run final", int'(dst_count), 15);
        chk("R7 at max before wrap", int'(dst_count), M - 1);
        drive_incs(1);
        wait_dst(6);
        chk("R7 wrap to zero", int'(dst_count), 0);
        drive_incs(5);
        wait_dst(6);
        chk("R3 five steps", int'(dst_count), 5);
        chk("R4 settled equals source", int'(dst_count), model);

        // Increment low: output must hold.
        for (int k = 0; k < 6; k++) begin
            wait_dst(3);
            chk("R3 hold with inc low", int'(dst_count), 5);
        end

        // Fast source: skips allowed, order and origin checked by monitor.
        slow_mode = 0;
        skips     = 0;
        src_half  = 1.5;
        repeat (4) @(negedge src_clk);
        drive_incs(70);
        wait_dst(6);
        chk("R6 fast run settled", int'(dst_count), model);
        chk("R6 skipping occurred", int'(skips > 0), 1);

        src_half = 14.5;
        repeat (3) @(negedge src_clk);
        slow_mode = 1;

        // Destination reset alone.
        mon_en = 0;
        @(negedge dst_clk);
        dst_rst_n = 1'b0;
        wait_dst(2);
        chk("R8 dst reset clears output", int'(dst_count), 0);
        dst_rst_n = 1'b1;
        wait_dst(6);
        chk("R8 output returns to source count", int'(dst_count), model);

        // Source reset alone.
        @(negedge src_clk);
        src_rst_n = 1'b0;
        repeat (2) @(negedge src_clk);
        src_rst_n = 1'b1;
        wait_dst(6);
        chk("R8 source reset reaches output", int'(dst_count), 0);
        exp_q.delete();
        last_seen = dst_count;
        mon_en    = 1;
        drive_incs(3);
        wait_dst(6);
        chk("R5 count after source reset", int'(dst_count), 3);

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end
endmodule